// File: doc/BRIEF.md
# Byte-Lane Static RAM Model

This block is a synthesizable behavioural model of a word-wide static RAM. It uses active-low control pins: a chip select, an output enable, a write enable and one byte enable for each 8-bit half of a 16-bit word. The shared bidirectional data bus is split into a data-in vector, a data-out vector and one drive-enable bit per byte lane. A board-level wrapper or an FPGA I/O buffer can then form the real tri-state bus from these signals.

The control pins are sampled on a fast simulation clock. A read is decoded from the sampled pins, and the addressed word appears on the lane outputs one clock later. A write to a lane lasts as long as chip select, write enable and that lane's byte enable are all low. When any one of the three goes high, the word is committed. It uses the address and data sampled on the last clock of the overlap. The storage is not initialised. The address width is a parameter. Its default is kept small, and it can be raised to 20 bits for a full-size array.

Top module: `sram_lane_model`

## Requirements
- R1: When cs_n was high on a sampling edge, both bits of dout_en are 0 after that edge, and no lane is written whatever the other pins are.
- R2: With cs_n low and we_n high, oe_n high leaves both dout_en bits at 0.
- R3: With cs_n low, lb_n and ub_n both high leave both lanes undriven and write nothing, whatever we_n and oe_n are.
- R4: A read (cs_n low, we_n high, oe_n low) drives lane 0 (dout[7:0], dout_en[0]) only if lb_n is low, and lane 1 (dout[15:8], dout_en[1]) only if ub_n is low. The data is that of the word at addr, and it is valid one clock after the sampling edge.
- R5: A write stores only the lanes whose byte enable is low. The other lane of that word keeps its stored value.
- R6: A lane's write commits on the first edge where cs_n, we_n or its byte enable is sampled high after the overlap. Any of the three ends the write, and the address and data of the last overlapping cycle are stored.
- R7: With we_n held low across several words, raising and lowering the byte enables marks off each word, and every word is written at its own address.
- R8: While a write overlap is sampled, dout_en is 0 on both lanes even with oe_n low.
- R9: A read sampled on the same edge that commits a write to the same address returns the newly written data.
- R10: Synchronous active-low reset clears dout_en and discards a write still in progress, so the stored word keeps its earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW | Word address |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| lb_n | input | 1 | Lower byte enable (bits 7:0), active low |
| ub_n | input | 1 | Upper byte enable (bits 15:8), active low |
| din | input | 16 | Write data from the bus |
| dout | output | 16 | Read data toward the bus |
| dout_en | output | 2 | Per-lane drive enable, bit 0 lower lane, bit 1 upper lane |

## Verification
A wrong lane tracking flag shows up in two ways at the ports. Either a word never lands, or it lands at the wrong moment, and the next read of that address shows the stale or foreign byte one clock after it is sampled. A faulty decode shows in dout_en on the cycle after the pins are sampled. Such a fault may drive a lane that should float, or drive during a write. A missing forwarding path shows only when a read is sampled on the exact edge that commits a write, so that case is tested directly.

// File: rtl/sram_lane_pkg.sv
// Shared constants and types of the byte-lane RAM model.
// Assumes two byte lanes of eight bits, matching the two byte-enable pins.
package sram_lane_pkg;
    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;

    // Per-lane decoded request for one sampled cycle.
    typedef struct packed {
        logic wr;   // write overlap active on this lane
        logic rd;   // read drive requested on this lane
    } lane_ctl_t;
endpackage

// File: rtl/sram_pin_decode.sv
// Decodes the sampled active-low control pins into per-lane read and
// write requests, following the control truth table.
// Assumes be_n[i] gates lane i; a write makes oe_n irrelevant.
module sram_pin_decode
    import sram_lane_pkg::*;
#(
    parameter int NL = LANES
) (
    input  logic                cs_n,
    input  logic                we_n,
    input  logic                oe_n,
    input  logic [NL-1:0]       be_n,
    output lane_ctl_t [NL-1:0]  ctl
);
    genvar g;
    generate
        for (g = 0; g < NL; g++) begin : g_lane
            // Purpose: per-lane overlap of select, direction and byte enable.
            always_comb begin
                ctl[g].wr = !cs_n && !we_n && !be_n[g];
                ctl[g].rd = !cs_n &&  we_n && !oe_n && !be_n[g];
            end
        end
    endgenerate
endmodule

// File: rtl/sram_lane.sv
// One byte lane: storage, write-overlap tracker and registered read port.
// Assumes addr and wdata are stable during a write overlap; the word is
// committed on the first edge that samples the overlap as ended, using the
// address and data captured on the last overlapping edge.
module sram_lane #(
    parameter int AW = 10,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_on,
    input  logic          rd_on,
    input  logic [LW-1:0] wdata,
    output logic [LW-1:0] rdata,
    output logic          drive
);
    localparam int DEPTH = 1 << AW;

    logic [LW-1:0] mem [DEPTH];
    logic          wr_q;
    logic [AW-1:0] wa_q;
    logic [LW-1:0] wd_q;
    logic          commit;
    logic          fwd;

    // Purpose: a commit is the falling end of the overlap, never under reset.
    always_comb begin
        commit = rst_n && wr_q && !wr_on;
        fwd    = commit && (wa_q == addr);
    end

    // Purpose: track the overlap and hold its last address and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= 1'b0;
        end else begin
            wr_q <= wr_on;
        end
        if (wr_on) begin
            wa_q <= addr;
            wd_q <= wdata;
        end
    end

    // Purpose: store the captured byte when the overlap ends.
    always_ff @(posedge clk) begin
        if (commit) begin
            mem[wa_q] <= wd_q;
        end
    end

    // Purpose: registered read with forwarding of a same-edge commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive <= 1'b0;
            rdata <= '0;
        end else begin
            drive <= rd_on;
            if (rd_on) begin
                rdata <= fwd ? wd_q : mem[addr];
            end else begin
                rdata <= '0;
            end
        end
    end
endmodule

// File: rtl/sram_lane_model.sv
// Top of the byte-lane static RAM model. Samples the pins on clk, decodes
// them per lane and hands each lane its slice of the split data bus.
// Assumes the bus wrapper turns dout/dout_en into the tri-state bus.
module sram_lane_model
    import sram_lane_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              lb_n,
    input  logic              ub_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic [LANES-1:0]  dout_en
);
    logic [LANES-1:0]      be_n;
    lane_ctl_t [LANES-1:0] ctl;

    // Purpose: lane 0 is the lower byte, lane 1 the upper byte.
    always_comb begin
        be_n = {ub_n, lb_n};
    end

    sram_pin_decode #(.NL(LANES)) u_dec (
        .cs_n (cs_n),
        .we_n (we_n),
        .oe_n (oe_n),
        .be_n (be_n),
        .ctl  (ctl)
    );

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            sram_lane #(.AW(AW), .LW(LANE_W)) u_lane (
                .clk   (clk),
                .rst_n (rst_n),
                .addr  (addr),
                .wr_on (ctl[g].wr),
                .rd_on (ctl[g].rd),
                .wdata (din[g*LANE_W +: LANE_W]),
                .rdata (dout[g*LANE_W +: LANE_W]),
                .drive (dout_en[g])
            );
        end
    endgenerate
endmodule

// File: rtl/sram_lane_model_chk.sv
// Port-level checker for the byte-lane RAM model, bound to the top.
// Assumes rst_n is low from time zero until the first few edges.
module sram_lane_model_chk #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr,
    input logic          cs_n,
    input logic          oe_n,
    input logic          we_n,
    input logic          lb_n,
    input logic          ub_n,
    input logic [15:0]   dout,
    input logic [1:0]    dout_en
);
    // R1
    cs_high_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (dout_en == 2'b00));
    // R2
    oe_high_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && we_n && oe_n) |=> (dout_en == 2'b00));
    // R3
    no_byte_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_n && ub_n) |=> (dout_en == 2'b00));
    // R4
    read_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && we_n && !oe_n) |=> (dout_en == {!$past(ub_n), !$past(lb_n)}));
    // R4
    low_lane_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lb_n |=> !dout_en[0]);
    // R8
    write_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !we_n) |=> (dout_en == 2'b00));
    // R4
    idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en[1] |-> (dout[15:8] == 8'h00));
endmodule

bind sram_lane_model sram_lane_model_chk #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .cs_n    (cs_n),
    .oe_n    (oe_n),
    .we_n    (we_n),
    .lb_n    (lb_n),
    .ub_n    (ub_n),
    .dout    (dout),
    .dout_en (dout_en)
);

// File: tb/sram_lane_model_test.sv
`timescale 1ns/1ps
module sram_lane_model_test;
    localparam int AW = 10;

    typedef struct packed {
        logic [1:0]  kind;   // 0 write, 1 read, 2 float probe
        logic        cs;
        logic        oe;
        logic        we;
        logic        ub;
        logic        lb;
        logic [1:0]  endm;   // write end: 0 we_n, 1 cs_n, 2 byte enables
        logic [3:0]  req;
        logic [9:0]  adr;
        logic [15:0] dat;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,4'd6,10'd3,   16'hA1B2}, // R6 end by we
        '{2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd1,4'd6,10'd4,   16'hC3D4}, // R6 end by cs
        '{2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd2,4'd6,10'd5,   16'h1122}, // R6 end by bytes
        '{2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,4'd6,10'd3,   16'h0000},
        '{2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,4'd6,10'd4,   16'h0000},
        '{2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,4'd6,10'd5,   16'h0000},
        '{2'd0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,4'd5,10'd3,   16'hFFEE}, // R5 low only
        '{2'd0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd2,4'd5,10'd4,   16'h7788}, // R5 high only
        '{2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,4'd5,10'd3,   16'h0000},
        '{2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,4'd5,10'd4,   16'h0000},
        '{2'd1,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,4'd4,10'd3,   16'h0000}, // R4 low lane
        '{2'd1,1'b0,1'b0,1'b0,1'b0,1'b1,2'd0,4'd4,10'd4,   16'h0000}, // R4 high lane
        '{2'd2,1'b1,1'b0,1'b0,1'b0,1'b0,2'd0,4'd1,10'd3,   16'h0000}, // R1
        '{2'd2,1'b0,1'b1,1'b1,1'b0,1'b0,2'd0,4'd2,10'd3,   16'h0000}, // R2
        '{2'd2,1'b0,1'b0,1'b0,1'b1,1'b1,2'd0,4'd3,10'd4,   16'h0000}, // R3 write
        '{2'd2,1'b0,1'b0,1'b1,1'b1,1'b1,2'd0,4'd3,10'd4,   16'h0000}, // R3 read
        '{2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,4'd1,10'd3,   16'h0000},
        '{2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,4'd3,10'd4,   16'h0000},
        '{2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,4'd4,10'd0,   16'h0F0F},
        '{2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd1,4'd4,10'd1023,16'h5AA5},
        '{2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,4'd4,10'd0,   16'h0000},
        '{2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,4'd4,10'd1023,16'h0000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
    logic [15:0]   din = '0;
    logic [15:0]   dout;
    logic [1:0]    dout_en;

    logic [15:0] ref_mem [1 << AW];
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sram_lane_model #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs_n(cs_n), .oe_n(oe_n),
        .we_n(we_n), .lb_n(lb_n), .ub_n(ub_n), .din(din), .dout(dout),
        .dout_en(dout_en)
    );

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic idle();
        cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; lb_n = 1'b1; ub_n = 1'b1;
    endtask

    // Write with oe_n low during the overlap; R8 checked mid-write.
    task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d,
                            input logic ub, input logic lb, input logic [1:0] endm,
                            input bit rd_after);
        @(negedge clk);
        addr = a; din = d; cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; ub_n = ub; lb_n = lb;
        @(negedge clk);
        check("R8", {30'd0, dout_en}, 32'd0);
        if (!lb) ref_mem[a][7:0]  = d[7:0];
        if (!ub) ref_mem[a][15:8] = d[15:8];
        din = ~d;
        if (rd_after) begin
            we_n = 1'b1; ub_n = 1'b0; lb_n = 1'b0;
        end else begin
            case (endm)
                2'd0:    we_n = 1'b1;
                2'd1:    cs_n = 1'b1;
                default: begin ub_n = 1'b1; lb_n = 1'b1; end
            endcase
        end
        @(negedge clk);
        if (rd_after) begin
            check("R9 en", {30'd0, dout_en}, 32'd3);
            check("R9 data", {16'd0, dout}, {16'd0, ref_mem[a]});
        end
        idle();
    endtask

    task automatic do_read(input string rq, input logic [AW-1:0] a,
                           input logic ub, input logic lb);
        logic [15:0] exp;
        @(negedge clk);
        addr = a; cs_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; ub_n = ub; lb_n = lb;
        @(negedge clk);
        exp = {ub ? 8'h00 : ref_mem[a][15:8], lb ? 8'h00 : ref_mem[a][7:0]};
        check(rq, {30'd0, dout_en}, {30'd0, !ub, !lb});
        if (!lb) check(rq, {24'd0, dout[7:0]},  {24'd0, exp[7:0]});
        if (!ub) check(rq, {24'd0, dout[15:8]}, {24'd0, exp[15:8]});
        idle();
    endtask

    task automatic do_probe(input string rq, input vec_t v);
        @(negedge clk);
        addr = v.adr; din = v.dat; cs_n = v.cs; oe_n = v.oe; we_n = v.we;
        ub_n = v.ub; lb_n = v.lb;
        @(negedge clk);
        check(rq, {30'd0, dout_en}, 32'd0);
        idle();
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R10: outputs quiet under reset.
        repeat (3) @(negedge clk);
        check("R10 reset", {30'd0, dout_en}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d vec%0d", VECS[i].req, i);
            case (VECS[i].kind)
                2'd0: do_write(VECS[i].adr, VECS[i].dat, VECS[i].ub, VECS[i].lb,
                               VECS[i].endm, 1'b0);
                2'd1: do_read(rq, VECS[i].adr, VECS[i].ub, VECS[i].lb);
                default: do_probe(rq, VECS[i]);
            endcase
        end

        // R7: we_n held low, byte enables frame two words.
        @(negedge clk);
        cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        addr = 10'd10; din = 16'h1234; lb_n = 1'b0; ub_n = 1'b0;
        @(negedge clk); lb_n = 1'b1; ub_n = 1'b1;
        @(negedge clk); addr = 10'd11; din = 16'h5678; lb_n = 1'b0; ub_n = 1'b0;
        @(negedge clk); lb_n = 1'b1; ub_n = 1'b1;
        @(negedge clk); idle();
        ref_mem[10] = 16'h1234;
        ref_mem[11] = 16'h5678;
        do_read("R7 word0", 10'd10, 1'b0, 1'b0);
        do_read("R7 word1", 10'd11, 1'b0, 1'b0);

        // R9: read sampled on the commit edge.
        do_write(10'd12, 16'hBEEF, 1'b0, 1'b0, 2'd0, 1'b1);

        // R10: reset in the middle of a write discards it.
        do_write(10'd20, 16'hAAAA, 1'b0, 1'b0, 2'd0, 1'b0);
        @(negedge clk);
        addr = 10'd20; din = 16'h5555; cs_n = 1'b0; we_n = 1'b0; lb_n = 1'b0; ub_n = 1'b0;
        @(negedge clk);
        idle(); rst_n = 1'b0;
        @(negedge clk);
        check("R10 reset en", {30'd0, dout_en}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        do_read("R10 discard", 10'd20, 1'b0, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule